// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, A and B. Each direction has its own storage register with its own capture clock. The A-to-B register stores the A bus, and the B-to-A register stores the B bus. The active-low enable and the direction input choose which bus, if any, the block drives. For the driven bus, a per-direction select chooses between live data from the other bus and the value held in the matching register.

Each bus is modelled as three separate vectors: an input, an output and a per-bit output-enable. A wrapper can turn these into tri-state pads, and the core stays plain synthesizable logic. Capture never depends on the enable or the direction. So a host can store data while the block is isolated and send it out later.

Top module: `bt_transceiver`

## Requirements
- R1: On each rising edge of `clk_ab_i`, the A-to-B register loads `a_i`, whatever `oe_ni`, `dir_i` and the selects are.
- R2: On each rising edge of `clk_ba_i`, the B-to-A register loads `b_i`, whatever `oe_ni`, `dir_i` and the selects are.
- R3: While `oe_ni` is 1 (isolation), `a_oe_o` and `b_oe_o` are both all zeros.
- R4: While `oe_ni` is 0, `dir_i` = 0 makes `a_oe_o` all ones and `b_oe_o` zero. `dir_i` = 1 makes `b_oe_o` all ones and `a_oe_o` zero.
- R5: While A is driven, `sel_ba_i` = 0 gives `a_o` = `b_i`. `sel_ba_i` = 1 gives `a_o` = the B-to-A register.
- R6: While B is driven, `sel_ab_i` = 0 gives `b_o` = `a_i`. `sel_ab_i` = 1 gives `b_o` = the A-to-B register.
- R7: `a_oe_o` and `b_oe_o` are never both non-zero.
- R8: While `rst_ni` is 0, both registers clear to 8'h00 at once (without a clock), and both enable vectors are zero.
- R9: A bus whose enable vector is zero shows 8'h00 on its data output.
- R10: After a value is captured from A and `a_i` then changes, selecting stored data with B driven shows the earlier captured value on `b_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_ab_i | input | 1 | Capture clock of the A-to-B register |
| clk_ba_i | input | 1 | Capture clock of the B-to-A register |
| oe_ni | input | 1 | Active-low output enable |
| dir_i | input | 1 | 0: drive A, 1: drive B |
| sel_ab_i | input | 1 | B output source: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | A output source: 0 live B, 1 stored B |
| a_i | input | 8 | A bus input |
| a_o | output | 8 | A bus output data |
| a_oe_o | output | 8 | A bus per-bit drive enable |
| b_i | input | 8 | B bus input |
| b_o | output | 8 | B bus output data |
| b_oe_o | output | 8 | B bus per-bit drive enable |

## Verification
Capture and stored-data transfer can fall in the same cycle. A register clock can rise while its own contents are being driven out with the stored select set. The bench provokes this by pulsing both capture clocks together while the block drives a bus from storage. It then checks that the driven output moves to the newly captured value, with no stale value left behind. The bench also captures under every enable and direction setting, and it compares the full 16-way control sweep against arithmetic expectations.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int unsigned BUS_W_DEF = 8;
  typedef enum logic {
    DIR_TO_A = 1'b0,
    DIR_TO_B = 1'b1
  } dir_e;
endpackage

// File: rtl/bt_cap_reg.sv
module bt_cap_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // capture is unconditional: no enable gating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/bt_out_path.sv
module bt_out_path #(
  parameter int unsigned W = 8
) (
  input  logic         drive_i,
  input  logic         use_store_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] oe_o
);
  logic [W-1:0] src;
  always_comb begin
    src    = use_store_i ? stored_i : live_i;
    data_o = drive_i ? src : '0;
    oe_o   = {W{drive_i}};
  end
endmodule

// File: rtl/bt_transceiver.sv
module bt_transceiver
  import bt_pkg::*;
#(
  parameter int unsigned W = BUS_W_DEF
) (
  input  logic         rst_ni,
  input  logic         clk_ab_i,
  input  logic         clk_ba_i,
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic [W-1:0] reg_ab, reg_ba;
  logic         drive_a, drive_b;
  dir_e         dir;

  assign dir     = dir_e'(dir_i);
  assign drive_a = rst_ni & ~oe_ni & (dir == DIR_TO_A);
  assign drive_b = rst_ni & ~oe_ni & (dir == DIR_TO_B);

  bt_cap_reg #(.W(W)) u_reg_ab (.clk_i(clk_ab_i), .rst_ni(rst_ni), .d_i(a_i), .q_o(reg_ab));
  bt_cap_reg #(.W(W)) u_reg_ba (.clk_i(clk_ba_i), .rst_ni(rst_ni), .d_i(b_i), .q_o(reg_ba));

  bt_out_path #(.W(W)) u_path_a (
    .drive_i(drive_a), .use_store_i(sel_ba_i), .live_i(b_i), .stored_i(reg_ba),
    .data_o(a_o), .oe_o(a_oe_o)
  );
  bt_out_path #(.W(W)) u_path_b (
    .drive_i(drive_b), .use_store_i(sel_ab_i), .live_i(a_i), .stored_i(reg_ab),
    .data_o(b_o), .oe_o(b_oe_o)
  );

  assert_isolation_R3: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    oe_ni |-> (a_oe_o == '0 && b_oe_o == '0));
  assert_dir_a_R4: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!oe_ni && !dir_i) |-> (&a_oe_o && b_oe_o == '0));
  assert_store_a_R5: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (!oe_ni && !dir_i && sel_ba_i) |-> (a_o == reg_ba));
  assert_store_b_R6: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!oe_ni && dir_i && sel_ab_i) |-> (b_o == reg_ab));
  assert_exclusive_R7: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !((|a_oe_o) && (|b_oe_o)));
  assert_idle_zero_R9: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (b_oe_o == '0) |-> (b_o == '0));
endmodule

// File: tb/sim_bt_transceiver.sv
module sim_bt_transceiver;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clk_ab = 1'b0, clk_ba = 1'b0;
  logic       oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out, a_oe, b_out, b_oe;
  logic [7:0] m_ab = '0, m_ba = '0;
  int         n_vec = 0, n_bad = 0;
  int unsigned cyc = 0;

  always #2 clk = ~clk;

  bt_transceiver u0 (
    .rst_ni(rst_ni), .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .oe_ni(oe_n), .dir_i(dir),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic pulse(input logic do_ab, input logic do_ba);
    @(negedge clk);
    clk_ab = do_ab; clk_ba = do_ba;
    if (do_ab) m_ab = a_in;
    if (do_ba) m_ba = b_in;
    @(negedge clk);
    clk_ab = 1'b0; clk_ba = 1'b0;
    #1;
  endtask

  // full expectation from requirements R3-R6, R9
  task automatic check_all(input string tag);
    logic       da, db;
    logic [7:0] ea, eb;
    da = !oe_n && !dir;
    db = !oe_n && dir;
    ea = da ? (sel_ba ? m_ba : b_in) : 8'h00;
    eb = db ? (sel_ab ? m_ab : a_in) : 8'h00;
    #1;
    chk({tag, " R4/R3 a_oe"}, a_oe, {8{da}});
    chk({tag, " R4/R3 b_oe"}, b_oe, {8{db}});
    chk({tag, " R5/R9 a_o"}, a_out, ea);
    chk({tag, " R6/R9 b_o"}, b_out, eb);
    chk({tag, " R7 excl"}, {7'd0, (|a_oe) & (|b_oe)}, 8'h00);
  endtask

  initial begin
    #3;
    // R8: reset state
    chk("R8 a_oe in reset", a_oe, 8'h00);
    chk("R8 b_oe in reset", b_oe, 8'h00);
    oe_n = 1'b0;
    #1;
    chk("R8 enable held off by reset", a_oe, 8'h00);
    oe_n = 1'b1;
    @(negedge clk); rst_ni = 1'b1; #1;
    check_all("post-reset");
    // R8: registers cleared -> stored data is zero
    oe_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1; a_in = 8'hA5; b_in = 8'h5A;
    dir = 1'b0; check_all("R8 cleared ba");
    dir = 1'b1; check_all("R8 cleared ab");

    // R1/R2 capture under every control setting, then full sweep
    for (int p = 0; p < 64; p++) begin
      oe_n = p[0]; dir = p[1]; sel_ab = p[2]; sel_ba = p[3];
      a_in = 8'((p * 37 + 5) & 8'hFF);
      b_in = 8'((p * 91 + 3) & 8'hFF);
      pulse(p[4] | ~p[5], p[5] | ~p[4]);
      a_in = 8'((p * 53 + 17) & 8'hFF);
      b_in = 8'((p * 29 + 201) & 8'hFF);
      for (int c = 0; c < 16; c++) begin
        oe_n = c[0]; dir = c[1]; sel_ab = c[2]; sel_ba = c[3];
        check_all("R1/R2 sweep");
      end
    end

    // R10 store-then-transfer
    oe_n = 1'b1; a_in = 8'h3C; pulse(1'b1, 1'b0);
    a_in = 8'hC3; oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
    chk("R10 stored A on B", b_out, 8'h3C);

    // simultaneous capture while transferring from storage
    for (int k = 0; k < 8; k++) begin
      oe_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1; dir = k[0];
      a_in = 8'(k * 17 + 1); b_in = 8'(k * 23 + 9);
      pulse(1'b1, 1'b1);
      chk("R1 capture during transfer", dir ? b_out : a_out, dir ? a_in - 8'h0 : b_in);
      check_all("R2 concurrent");
    end

    // R8 async clear mid-run
    rst_ni = 1'b0; #1;
    chk("R8 a_oe async", a_oe, 8'h00);
    chk("R8 b_oe async", b_oe, 8'h00);
    m_ab = '0; m_ba = '0;
    rst_ni = 1'b1; #1;
    check_all("R8 after clear");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog R1..: run hung got=%0d exp<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule